// File: doc/BRIEF.md
# Fourteen-bit ALU with carry, negative, overflow and zero flags

This block is the arithmetic and logic stage of a small register-register processor. Each cycle the caller presents an operation code, a destination operand, a source operand, a shift count and the current carry and overflow flags. The source operand is either a second register or a 14-bit immediate. Instruction decode decides which one to present, and the block handles both the same way.

One clock edge later the block presents the value to write back to the destination. It also presents the value to write back to the source register, which differs from the input only for a swap. The four new status flags are presented at the same time.

Arithmetic shift right and rotate right take a 4-bit count. The rotate treats the carry flag and the 14 data bits as one 15-bit ring. The register file, decode and memory access sit outside the block.

Top module: `alu14_core`

## Requirements
- R1: Operation codes are: 0 copy, 1 swap, 2 add, 3 subtract, 4 add constant, 5 subtract constant, 6 AND, 7 OR, 8 NOT, 9 arithmetic shift right, 10 rotate right. Copy returns the source as the new destination. Swap returns the source as the new destination and the destination as the new source. Every operation other than swap returns the source unchanged on `src_out`.
- R2: Add (codes 2 and 4) returns the 14-bit sum. C is the carry out of bit 13. V is set when both operands share a sign and the sum's sign differs from it.
- R3: Subtract (codes 3 and 5) returns destination minus source modulo 2^14. C is set when no borrow occurs (destination ≥ source, unsigned). V is set when the operand signs differ and the result's sign differs from the destination's.
- R4: AND, OR and NOT act bitwise on the destination, with the source as the second operand for AND and OR. These operations, along with copy and swap, copy `c_in` to `c_out` and `v_in` to `v_out`.
- R5: For every operation, N equals bit 13 of the new destination value, and Z is set exactly when the new destination value is zero.
- R6: Arithmetic shift right by k (1 to 14) replicates bit 13 into the vacated positions. C takes the last bit shifted out, which is destination bit k-1. V passes through from `v_in`.
- R7: Rotate right by k treats {carry, data[13:0]} as a 15-bit ring and rotates it right k places. Data bit 0 moves into the carry and the carry moves into bit 13. The new carry is ring bit 14 afterwards. V passes through.
- R8: A shift or rotate with a count of 0 returns the destination unchanged and passes `c_in` to `c_out`.
- R9: A count of 15 on a shift or rotate acts as a count of 14.
- R10: Codes 11 to 15 are reserved. They return the destination and source unchanged and pass C and V through.
- R11: Outputs are registered. The results for inputs sampled at one rising edge appear after that edge and hold until the next.
- R12: While `rst_n` is low at a rising edge, both data outputs clear to zero, Z is set, and C, N and V clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code |
| dst_in | input | 14 | Destination operand |
| src_in | input | 14 | Source operand (register or immediate) |
| shamt | input | 4 | Shift or rotate count |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| dst_out | output | 14 | New destination value |
| src_out | output | 14 | New source value (differs only on swap) |
| c_out | output | 1 | New carry flag |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |

## Verification
The bench drives signed overflow in both directions on add and subtract, a subtract of equal operands, and a wrap of 0x3FFF+1. These catch a swapped borrow sense or a mis-signed overflow term, which would show as a wrong C or V with the right data.

It also rotates by 0, 1, 14 and 15. A ring that left out the carry, or a clamp missing for count 15, shows up here as wrong data bits or a wrong carry.

An arithmetic shift of 0x2000 by 14 exposes a logical shift, which would return 0 instead of 0x3FFF. Random vectors with both flag inputs varied catch logic operations that disturb C or V. They also catch a swap that fails to return both operands.

// File: rtl/alu14_pkg.sv
// Package alu14_pkg
// Shared operation encoding for the 14-bit ALU. Codes above OP_ROR are
// reserved and treated as no-operation by the core.
package alu14_pkg;
    typedef enum logic [3:0] {
        OP_CPY  = 4'd0,
        OP_SWP  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_ADDI = 4'd4,
        OP_SUBI = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_NOT  = 4'd8,
        OP_ASR  = 4'd9,
        OP_ROR  = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic n;
        logic v;
        logic z;
    } alu_flags_t;
endpackage

// File: rtl/alu14_addsub.sv
// Module alu14_addsub
// Two's-complement adder/subtractor. With sub high it forms a + ~b + 1.
// The carry output is then the not-borrow flag. Purely combinational.
module alu14_addsub #(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    // Invert the second operand for subtraction and add with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu14_shift.sv
// Module alu14_shift
// Arithmetic shift right and rotate right through carry. Counts above W
// saturate to W. A count of zero returns the data and the carry as given.
// The rotate ring is {cin, d}, W+1 bits wide.
module alu14_shift #(
    parameter int W  = 14,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  d,
    input  logic [CW-1:0] cnt,
    input  logic          cin,
    input  logic          rot,
    output logic [W-1:0]  q,
    output logic          cout
);
    localparam logic [CW-1:0] CMAX = CW'(W);

    logic [CW-1:0]    kk;
    logic [W-1:0]     asr_q;
    logic             asr_c;
    logic [2*W+1:0]   dbl;
    logic [W:0]       ring;

    // Clamp the count to the data width.
    always_comb kk = (cnt > CMAX) ? CMAX : cnt;

    // Arithmetic shift; the carry takes the last bit shifted out.
    always_comb begin
        asr_q = W'($signed(d) >>> kk);
        asr_c = cin;
        for (int i = 0; i < W; i++) begin
            if (kk == CW'(i + 1)) asr_c = d[i];
        end
    end

    // Rotate the (W+1)-bit ring by shifting a doubled copy.
    always_comb begin
        dbl  = {cin, d, cin, d} >> kk;
        ring = dbl[W:0];
    end

    // Select the variant requested.
    always_comb begin
        if (rot) begin
            q    = ring[W-1:0];
            cout = ring[W];
        end else begin
            q    = asr_q;
            cout = asr_c;
        end
    end
endmodule

// File: rtl/alu14_logic.sv
// Module alu14_logic
// Bitwise AND, OR and NOT of the destination operand. sel: 0 AND, 1 OR,
// 2 and 3 NOT. Combinational.
module alu14_logic #(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] q
);
    // Pick the bitwise function.
    always_comb begin
        unique case (sel)
            2'd0:    q = a & b;
            2'd1:    q = a | b;
            default: q = ~a;
        endcase
    end
endmodule

// File: rtl/alu14_core.sv
// Module alu14_core
// Top of the ALU. It decodes the operation, steers operands into the
// add/sub, shift and logic units, and forms N and Z from the new
// destination. Results and flags are registered with one cycle of latency.
// Assumes: the caller selects register or immediate onto src_in, and
// reserved op codes act as no-operation.
module alu14_core
    import alu14_pkg::*;
#(
    parameter int W = 14,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [W-1:0]  dst_in,
    input  logic [W-1:0]  src_in,
    input  logic [CW-1:0] shamt,
    input  logic          c_in,
    input  logic          v_in,
    output logic [W-1:0]  dst_out,
    output logic [W-1:0]  src_out,
    output logic          c_out,
    output logic          n_out,
    output logic          v_out,
    output logic          z_out
);
    alu_op_e      op;
    logic         as_sub;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_v;
    logic         sh_rot;
    logic [W-1:0] sh_q;
    logic         sh_c;
    logic [1:0]   lg_sel;
    logic [W-1:0] lg_q;
    logic [W-1:0] nxt_dst;
    logic [W-1:0] nxt_src;
    alu_flags_t   nxt_f;

    // Decode the op code and the unit control lines.
    always_comb begin
        op     = alu_op_e'(op_sel);
        as_sub = (op == OP_SUB) || (op == OP_SUBI);
        sh_rot = (op == OP_ROR);
        lg_sel = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;
    end

    alu14_addsub #(.W(W)) i_addsub (
        .a    (dst_in),
        .b    (src_in),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_c),
        .ovf  (as_v)
    );

    alu14_shift #(.W(W), .CW(CW)) i_shift (
        .d    (dst_in),
        .cnt  (shamt),
        .cin  (c_in),
        .rot  (sh_rot),
        .q    (sh_q),
        .cout (sh_c)
    );

    alu14_logic #(.W(W)) i_logic (
        .a   (dst_in),
        .b   (src_in),
        .sel (lg_sel),
        .q   (lg_q)
    );

    // Choose the write-back values and C/V per operation.
    always_comb begin
        nxt_dst = dst_in;
        nxt_src = src_in;
        nxt_f.c = c_in;
        nxt_f.v = v_in;
        unique case (op)
            OP_CPY: nxt_dst = src_in;
            OP_SWP: begin
                nxt_dst = src_in;
                nxt_src = dst_in;
            end
            OP_ADD, OP_ADDI, OP_SUB, OP_SUBI: begin
                nxt_dst = as_sum;
                nxt_f.c = as_c;
                nxt_f.v = as_v;
            end
            OP_AND, OP_OR, OP_NOT: nxt_dst = lg_q;
            OP_ASR, OP_ROR: begin
                nxt_dst = sh_q;
                nxt_f.c = sh_c;
            end
            default: ;
        endcase
        nxt_f.n = nxt_dst[W-1];
        nxt_f.z = (nxt_dst == '0);
    end

    // Register results and flags; reset to zero data with Z set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_out <= '0;
            src_out <= '0;
            c_out   <= 1'b0;
            n_out   <= 1'b0;
            v_out   <= 1'b0;
            z_out   <= 1'b1;
        end else begin
            dst_out <= nxt_dst;
            src_out <= nxt_src;
            c_out   <= nxt_f.c;
            n_out   <= nxt_f.n;
            v_out   <= nxt_f.v;
            z_out   <= nxt_f.z;
        end
    end
endmodule

// File: rtl/alu14_chk.sv
// Module alu14_chk
// Property checker for alu14_core, attached by bind. It relates the
// registered outputs to the inputs of the previous cycle.
module alu14_chk #(
    parameter int W  = 14,
    parameter int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_sel,
    input logic [W-1:0]  dst_in,
    input logic [W-1:0]  src_in,
    input logic [CW-1:0] shamt,
    input logic          c_in,
    input logic          v_in,
    input logic [W-1:0]  dst_out,
    input logic [W-1:0]  src_out,
    input logic          c_out,
    input logic          n_out,
    input logic          v_out,
    input logic          z_out
);
    logic primed;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_SWAP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_sel) == 4'd1 |-> dst_out == $past(src_in) && src_out == $past(dst_in)); // R1
    AST_SRC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_sel) != 4'd1 |-> src_out == $past(src_in)); // R1
    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_sel) >= 4'd6 && $past(op_sel) <= 4'd8) |-> c_out == $past(c_in) && v_out == $past(v_in)); // R4
    AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> n_out == dst_out[W-1] && z_out == (dst_out == '0)); // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(op_sel) == 4'd9 || $past(op_sel) == 4'd10) && $past(shamt) == '0
        |-> dst_out == $past(dst_in) && c_out == $past(c_in)); // R8
    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_sel) >= 4'd11 |-> dst_out == $past(dst_in) && c_out == $past(c_in) && v_out == $past(v_in)); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> dst_out == '0 && z_out && !c_out); // R12
endmodule

bind alu14_core alu14_chk #(.W(W), .CW(CW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .dst_in  (dst_in),
    .src_in  (src_in),
    .shamt   (shamt),
    .c_in    (c_in),
    .v_in    (v_in),
    .dst_out (dst_out),
    .src_out (src_out),
    .c_out   (c_out),
    .n_out   (n_out),
    .v_out   (v_out),
    .z_out   (z_out)
);

// File: tb/test_alu14_core.sv
// Bench for alu14_core: directed corner cases plus seeded random vectors,
// compared against a behavioural model written from the requirements.
module test_alu14_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_sel;
    logic [13:0] dst_in, src_in;
    logic [3:0]  shamt;
    logic        c_in, v_in;
    logic [13:0] dst_out, src_out;
    logic        c_out, n_out, v_out, z_out;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    alu14_core i_alu14_core (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dst_in(dst_in),
        .src_in(src_in), .shamt(shamt), .c_in(c_in), .v_in(v_in),
        .dst_out(dst_out), .src_out(src_out), .c_out(c_out),
        .n_out(n_out), .v_out(v_out), .z_out(z_out)
    );

    // Model returns {dst[13:0], src[13:0], c, n, v, z}.
    function automatic logic [31:0] model(input logic [3:0] op, input logic [13:0] d,
                                          input logic [13:0] s, input logic [3:0] k,
                                          input logic c, input logic v);
        logic [13:0] nd = d;
        logic [13:0] ns = s;
        logic        nc = c;
        logic        nv = v;
        logic        t;
        int          kk = (k > 4'd14) ? 14 : int'(k);
        int          sum;
        case (op)
            4'd0: nd = s;
            4'd1: begin nd = s; ns = d; end
            4'd2, 4'd4: begin
                sum = int'(d) + int'(s);
                nd  = sum[13:0];
                nc  = sum >= 16384;
                nv  = (d[13] == s[13]) && (nd[13] != d[13]);
            end
            4'd3, 4'd5: begin
                sum = int'(d) - int'(s);
                nd  = sum[13:0];
                nc  = d >= s;
                nv  = (d[13] != s[13]) && (nd[13] != d[13]);
            end
            4'd6: nd = d & s;
            4'd7: nd = d | s;
            4'd8: nd = ~d;
            4'd9: for (int i = 0; i < kk; i++) begin
                nc = nd[0];
                nd = {nd[13], nd[13:1]};
            end
            4'd10: for (int i = 0; i < kk; i++) begin
                t  = nd[0];
                nd = {nc, nd[13:1]};
                nc = t;
            end
            default: ;
        endcase
        return {nd, ns, nc, nd[13], nv, nd == 14'd0};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [3:0] k);
        if ((op == 4'd9 || op == 4'd10) && k == 4'd0) return "R8";
        if ((op == 4'd9 || op == 4'd10) && k == 4'd15) return "R9";
        case (op)
            4'd0, 4'd1:         return "R1";
            4'd2, 4'd4:         return "R2";
            4'd3, 4'd5:         return "R3";
            4'd6, 4'd7, 4'd8:   return "R4";
            4'd9:               return "R6";
            4'd10:              return "R7";
            default:            return "R10";
        endcase
    endfunction

    // Apply one vector at a falling edge, check it one clock later (R11, R5).
    task automatic apply(input logic [3:0] op, input logic [13:0] d, input logic [13:0] s,
                         input logic [3:0] k, input logic c, input logic v);
        logic [31:0] exp;
        logic [31:0] got;
        op_sel = op; dst_in = d; src_in = s; shamt = k; c_in = c; v_in = v;
        exp = model(op, d, s, k, c, v);
        @(negedge clk);
        got = {dst_out, src_out, c_out, n_out, v_out, z_out};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s/R5/R11 op=%0d d=%h s=%h k=%0d c=%b v=%b: got %h expected %h",
                     tag_of(op, k), op, d, s, k, c, v, got, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; op_sel = 4'd2; dst_in = 14'h1234; src_in = 14'h0F0F;
        shamt = 4'd3; c_in = 1'b1; v_in = 1'b1;
        repeat (3) @(negedge clk);
        n_vec++;
        if ({dst_out, src_out, c_out, n_out, v_out, z_out} !== {28'd0, 4'b0001}) begin
            n_bad++;
            $display("FAIL R12: got %h expected %h",
                     {dst_out, src_out, c_out, n_out, v_out, z_out}, {28'd0, 4'b0001});
        end
        rst_n = 1'b1;
        // R2: positive overflow, wrap to zero with carry
        apply(4'd2, 14'h1FFF, 14'h0001, 4'd0, 1'b0, 1'b0);
        apply(4'd4, 14'h3FFF, 14'h0001, 4'd0, 1'b0, 1'b0);
        apply(4'd2, 14'h2000, 14'h2000, 4'd0, 1'b0, 1'b0);
        // R3: negative overflow, equal operands, borrow
        apply(4'd3, 14'h2000, 14'h0001, 4'd0, 1'b0, 1'b0);
        apply(4'd5, 14'h0155, 14'h0155, 4'd0, 1'b0, 1'b0);
        apply(4'd3, 14'h0001, 14'h0002, 4'd0, 1'b1, 1'b1);
        // R1: swap and copy
        apply(4'd1, 14'h0ABC, 14'h3123, 4'd0, 1'b1, 1'b0);
        apply(4'd0, 14'h0ABC, 14'h0000, 4'd0, 1'b0, 1'b1);
        // R4: logic keeps C and V
        apply(4'd8, 14'h3FFF, 14'h1111, 4'd0, 1'b1, 1'b1);
        apply(4'd7, 14'h2000, 14'h0001, 4'd0, 1'b1, 1'b0);
        // R6: sign replication and last-out carry
        apply(4'd9, 14'h2000, 14'h0000, 4'd14, 1'b0, 1'b1);
        apply(4'd9, 14'h0003, 14'h0000, 4'd1, 1'b0, 1'b0);
        // R7: ring rotation by 1 and 14
        apply(4'd10, 14'h0001, 14'h0000, 4'd1, 1'b0, 1'b0);
        apply(4'd10, 14'h0000, 14'h0000, 4'd1, 1'b1, 1'b0);
        apply(4'd10, 14'h2A5B, 14'h0000, 4'd14, 1'b1, 1'b0);
        // R8: zero count; R9: count 15 saturates
        apply(4'd10, 14'h1234, 14'h0000, 4'd0, 1'b1, 1'b0);
        apply(4'd9, 14'h2345, 14'h0000, 4'd0, 1'b0, 1'b1);
        apply(4'd10, 14'h2A5B, 14'h0000, 4'd15, 1'b0, 1'b0);
        apply(4'd9, 14'h1000, 14'h0000, 4'd15, 1'b1, 1'b0);
        // R10: reserved codes
        apply(4'd11, 14'h0000, 14'h3333, 4'd2, 1'b1, 1'b1);
        apply(4'd15, 14'h2001, 14'h0444, 4'd5, 1'b0, 1'b1);
        for (int n = 0; n < 4000; n++) begin
            apply(4'($urandom_range(0, 15)), 14'($urandom), 14'($urandom),
                  4'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule